// File: doc/BRIEF.md
# Fast Ethernet Link Status Monitor

This block decides whether the 100 Mb/s receive path of a physical-layer device has a usable link. It watches three indications from the receive datapath: a signal-level-valid flag from the analog detector, a lock flag from the descrambler, and a one-cycle strobe for every idle or data code group that is received. From these it keeps its own view of descrambler lock, guarded by a timeout. It produces a link status output and a one-cycle loss-of-synchronisation pulse.

The lock view is taken on a rising edge of the descrambler-lock input. A timer then holds it, and every code-group strobe reloads that timer. If the strobes stop for a whole timeout window, the lock view is dropped and the pulse fires. The window is either a short value of 722 µs or a long value of 2 ms. The long value lets jumbo frames longer than 9 kbytes pass without a false loss of sync. The window length is derived from a clock-frequency parameter, and a divider parameter lets a bench shrink both windows.

Configuration inputs choose several behaviours. One input picks whether the link survives a loss of lock while the signal stays valid. Another forces the signal to read as valid. A third selects the long timeout. A good link can also be forced, either by a configuration input or by an external pin from the MAC; the two are combined with a logical OR.

Top module: `fel_link_mon`

## Requirements
- R1: While the synchronous reset is high, link status, the lock view and the loss-of-sync pulse are all 0 after each clock edge.
- R2: The link comes up at the same clock edge that samples a rising edge on the descrambler-lock input while the effective signal is valid. A lock edge sampled while the signal is invalid leaves the link down.
- R3: With the hold-on-signal input at 1, the link stays up after the lock view clears, for as long as the effective signal stays valid.
- R4: With the hold-on-signal input at 0, the link goes down one clock edge after the lock view clears.
- R5: The link goes down at the first clock edge that samples an invalid effective signal, whatever the hold setting, unless a force is active.
- R6: Let N be the selected timeout in cycles, computed as CLK_MHZ*T_ns/1000/TMO_DIV with integer division and a minimum of 1. A reload is a lock rising edge or a code-group strobe. If no strobe is sampled after a reload, the lock view clears at the N-th edge after that reload, and the loss-of-sync output is 1 for exactly that one cycle. A strobe at exactly the N-th edge keeps the lock view.
- R7: When the long-timeout input is 1, the timeout is 2 ms; when it is 0, the timeout is 722 µs. The input is read only at a reload, so changing it between reloads leaves the running window unchanged.
- R8: When the configuration force input or the MAC force pin is 1 at a clock edge, the link is 1 after that edge, regardless of signal and lock. Once both are 0, the link follows the normal rules again from the next edge.
- R9: When the force-signal input is 1, the signal-level input is treated as valid.
- R10: After the link has dropped, it comes back only on a new lock rising edge sampled while the signal is valid. A signal that returns while the lock view is still held does not raise the link.
- R11: When the descrambler-lock input is 0 at a clock edge, the lock view clears at that edge, and no loss-of-sync pulse is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| sig_det_i | input | 1 | Signal level valid from the analog detector |
| dscr_lock_i | input | 1 | Lock indication from the descrambler |
| cg_strobe_i | input | 1 | One-cycle pulse for each valid idle or data code group |
| cfg_hold_on_sig_i | input | 1 | 1: link survives lock loss while the signal is valid; 0: lock loss drops the link |
| cfg_sd_force_i | input | 1 | Treat the signal level as valid |
| cfg_force_link_i | input | 1 | Configuration force of a good link |
| mac_force_link_i | input | 1 | External force-good-link pin from the MAC |
| cfg_long_tmo_i | input | 1 | 1: 2 ms lock timeout; 0: 722 µs |
| link_up_o | output | 1 | 100 Mb/s link status |
| lock_o | output | 1 | Timed lock view held by the block |
| loss_sync_o | output | 1 | One-cycle pulse when the lock timeout expires |

## Verification
All three outputs are registered. Link and lock respond at the same clock edge that samples a lock rising edge, a signal loss or a force. A link drop caused by lock loss in drop mode comes one edge after the lock view clears. The loss-of-sync pulse and the clearing of the lock view both fall on the N-th edge after the last reload. The bench drives its inputs 1 ns after a rising edge and reads the outputs 1 ns after the next rising edge, so every expectation is tied to a counted edge. The timeout sweeps check every cycle of both windows against an N that the bench computes from the parameters itself.

// File: rtl/fel_pkg.sv
package fel_pkg;

    typedef enum logic {
        LNK_DOWN = 1'b0,
        LNK_UP   = 1'b1
    } link_state_e;

    typedef struct packed {
        logic hold_on_sig;
        logic sd_force;
        logic force_link;
        logic long_tmo;
    } link_cfg_t;

    // Cycles in a window of ns nanoseconds at clk_mhz, shrunk by div.
    function automatic int unsigned tmo_cycles(int unsigned clk_mhz,
                                               int unsigned ns,
                                               int unsigned div);
        longint unsigned prod;
        prod = (64'(clk_mhz) * 64'(ns)) / (64'd1000 * 64'(div));
        if (prod == 64'd0) prod = 64'd1;
        return 32'(prod);
    endfunction

    // Bits needed to hold values up to n-1.
    function automatic int unsigned cnt_bits(int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

    function automatic int unsigned max_u(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/fel_sig_qual.sv
module fel_sig_qual (
    input  logic sig_det_i,
    input  logic sd_force_i,
    input  logic force_reg_i,
    input  logic force_pin_i,
    output logic sig_ok_o,
    output logic force_any_o
);
    // Forced signal detect overrides the analog detector.
    assign sig_ok_o    = sig_det_i | sd_force_i;
    // Good-link force from either source.
    assign force_any_o = force_reg_i | force_pin_i;
endmodule

// File: rtl/fel_lock_timer.sv
module fel_lock_timer #(
    parameter int unsigned SHORT_CYC = 90250,
    parameter int unsigned LONG_CYC  = 250000,
    parameter int unsigned CW        = 18
) (
    input  logic clk,
    input  logic rst,
    input  logic lock_in_i,
    input  logic strobe_i,
    input  logic long_sel_i,
    output logic lock_o,
    output logic lock_evt_o,
    output logic loss_pulse_o
);
    localparam logic [CW-1:0] SHORT_LD = CW'(SHORT_CYC - 1);
    localparam logic [CW-1:0] LONG_LD  = CW'(LONG_CYC - 1);

    logic          lock_in_q;
    logic [CW-1:0] cnt_q;
    logic          reload;
    logic          expire;

    assign lock_evt_o = lock_in_i & ~lock_in_q;
    assign reload     = lock_evt_o | strobe_i;
    assign expire     = lock_o & lock_in_i & ~reload & (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            lock_in_q    <= 1'b0;
            cnt_q        <= '0;
            lock_o       <= 1'b0;
            loss_pulse_o <= 1'b0;
        end else begin
            lock_in_q    <= lock_in_i;
            loss_pulse_o <= expire;

            // Window length is latched only when the timer reloads.
            if (reload) begin
                cnt_q <= long_sel_i ? LONG_LD : SHORT_LD;
            end else if (lock_o && (cnt_q != '0)) begin
                cnt_q <= cnt_q - 1'b1;
            end

            if (!lock_in_i) begin
                lock_o <= 1'b0;
            end else if (lock_evt_o) begin
                lock_o <= 1'b1;
            end else if (expire) begin
                lock_o <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/fel_link_fsm.sv
module fel_link_fsm
    import fel_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic sig_ok_i,
    input  logic lock_i,
    input  logic lock_evt_i,
    input  logic hold_on_sig_i,
    input  logic force_i,
    output logic link_up_o
);
    link_state_e state_q, state_d;
    logic        lock_ok;

    assign lock_ok = lock_i | lock_evt_i;

    always_comb begin
        state_d = state_q;
        if (force_i) begin
            state_d = LNK_UP;
        end else begin
            unique case (state_q)
                LNK_DOWN: if (sig_ok_i && lock_evt_i) state_d = LNK_UP;
                LNK_UP: begin
                    if (!sig_ok_i)                         state_d = LNK_DOWN;
                    else if (!hold_on_sig_i && !lock_ok)   state_d = LNK_DOWN;
                end
                default: state_d = LNK_DOWN;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= LNK_DOWN;
        else     state_q <= state_d;
    end

    assign link_up_o = (state_q == LNK_UP);
endmodule

// File: rtl/fel_link_mon.sv
module fel_link_mon
    import fel_pkg::*;
#(
    parameter int unsigned CLK_MHZ  = 125,
    parameter int unsigned SHORT_NS = 722000,
    parameter int unsigned LONG_NS  = 2000000,
    parameter int unsigned TMO_DIV  = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic sig_det_i,
    input  logic dscr_lock_i,
    input  logic cg_strobe_i,
    input  logic cfg_hold_on_sig_i,
    input  logic cfg_sd_force_i,
    input  logic cfg_force_link_i,
    input  logic mac_force_link_i,
    input  logic cfg_long_tmo_i,
    output logic link_up_o,
    output logic lock_o,
    output logic loss_sync_o
);
    localparam int unsigned SHORT_CYC = tmo_cycles(CLK_MHZ, SHORT_NS, TMO_DIV);
    localparam int unsigned LONG_CYC  = tmo_cycles(CLK_MHZ, LONG_NS, TMO_DIV);
    localparam int unsigned CW        = cnt_bits(max_u(SHORT_CYC, LONG_CYC));

    link_cfg_t cfg;
    logic      sig_ok;
    logic      force_any;
    logic      lock_evt;

    assign cfg = '{hold_on_sig: cfg_hold_on_sig_i,
                   sd_force:    cfg_sd_force_i,
                   force_link:  cfg_force_link_i,
                   long_tmo:    cfg_long_tmo_i};

    fel_sig_qual u_qual (
        .sig_det_i   (sig_det_i),
        .sd_force_i  (cfg.sd_force),
        .force_reg_i (cfg.force_link),
        .force_pin_i (mac_force_link_i),
        .sig_ok_o    (sig_ok),
        .force_any_o (force_any)
    );

    fel_lock_timer #(
        .SHORT_CYC (SHORT_CYC),
        .LONG_CYC  (LONG_CYC),
        .CW        (CW)
    ) u_timer (
        .clk          (clk),
        .rst          (rst),
        .lock_in_i    (dscr_lock_i),
        .strobe_i     (cg_strobe_i),
        .long_sel_i   (cfg.long_tmo),
        .lock_o       (lock_o),
        .lock_evt_o   (lock_evt),
        .loss_pulse_o (loss_sync_o)
    );

    fel_link_fsm u_fsm (
        .clk           (clk),
        .rst           (rst),
        .sig_ok_i      (sig_ok),
        .lock_i        (lock_o),
        .lock_evt_i    (lock_evt),
        .hold_on_sig_i (cfg.hold_on_sig),
        .force_i       (force_any),
        .link_up_o     (link_up_o)
    );
endmodule

// File: rtl/fel_link_mon_chk.sv
module fel_link_mon_chk (
    input logic clk,
    input logic rst,
    input logic sig_det_i,
    input logic dscr_lock_i,
    input logic cfg_hold_on_sig_i,
    input logic cfg_sd_force_i,
    input logic cfg_force_link_i,
    input logic mac_force_link_i,
    input logic link_up_o,
    input logic lock_o,
    input logic loss_sync_o
);
    logic frc;
    logic sig_eff;
    assign frc     = cfg_force_link_i | mac_force_link_i;
    assign sig_eff = sig_det_i | cfg_sd_force_i;

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (!link_up_o && !lock_o && !loss_sync_o));

    // R2
    link_rise_locked_chk: assert property (@(posedge clk) disable iff (rst)
        (link_up_o && !$past(link_up_o) && !$past(frc)) |-> lock_o);

    // R4
    drop_on_unlock_chk: assert property (@(posedge clk) disable iff (rst)
        (!cfg_hold_on_sig_i && !lock_o && !dscr_lock_i && !frc) |=> !link_up_o);

    // R5 R9
    drop_on_sig_loss_chk: assert property (@(posedge clk) disable iff (rst)
        (!sig_eff && !frc) |=> !link_up_o);

    // R6
    loss_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        loss_sync_o |=> !loss_sync_o);

    // R6 R11
    loss_with_unlock_chk: assert property (@(posedge clk) disable iff (rst)
        loss_sync_o |-> (!lock_o && $past(lock_o) && $past(dscr_lock_i)));

    // R8
    forced_link_chk: assert property (@(posedge clk) disable iff (rst)
        frc |=> link_up_o);
endmodule

bind fel_link_mon fel_link_mon_chk u_chk (
    .clk               (clk),
    .rst               (rst),
    .sig_det_i         (sig_det_i),
    .dscr_lock_i       (dscr_lock_i),
    .cfg_hold_on_sig_i (cfg_hold_on_sig_i),
    .cfg_sd_force_i    (cfg_sd_force_i),
    .cfg_force_link_i  (cfg_force_link_i),
    .mac_force_link_i  (mac_force_link_i),
    .link_up_o         (link_up_o),
    .lock_o            (lock_o),
    .loss_sync_o       (loss_sync_o)
);

// File: tb/test_fel_link_mon.sv
`timescale 1ns/1ps
module test_fel_link_mon;
    localparam int unsigned CLK_MHZ  = 125;
    localparam int unsigned SHORT_NS = 722000;
    localparam int unsigned LONG_NS  = 2000000;
    localparam int unsigned TMO_DIV  = 1000;
    localparam int NS = int'((longint'(CLK_MHZ) * SHORT_NS) / 1000 / TMO_DIV);
    localparam int NL = int'((longint'(CLK_MHZ) * LONG_NS) / 1000 / TMO_DIV);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sig = 1'b0, dlk = 1'b0, stb = 1'b0;
    logic hold = 1'b1, sdf = 1'b0, frc_r = 1'b0, frc_p = 1'b0, lng = 1'b0;
    logic link, lock, loss;
    int   nvec = 0, nbad = 0;
    bit   done = 1'b0;

    always #2.5 clk = ~clk;

    fel_link_mon #(
        .CLK_MHZ (CLK_MHZ), .SHORT_NS (SHORT_NS),
        .LONG_NS (LONG_NS), .TMO_DIV (TMO_DIV)
    ) i_fel_link_mon (
        .clk (clk), .rst (rst),
        .sig_det_i (sig), .dscr_lock_i (dlk), .cg_strobe_i (stb),
        .cfg_hold_on_sig_i (hold), .cfg_sd_force_i (sdf),
        .cfg_force_link_i (frc_r), .mac_force_link_i (frc_p),
        .cfg_long_tmo_i (lng),
        .link_up_o (link), .lock_o (lock), .loss_sync_o (loss)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    // Compares {link, lock, loss} against the expectation.
    task automatic chk(string req, logic [2:0] exp);
        nvec++;
        if ({link, lock, loss} !== exp) begin
            nbad++;
            $display("FAIL %s: {link,lock,loss} actual %b expected %b at %0t",
                     req, {link, lock, loss}, exp, $time);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1; sig = 0; dlk = 0; stb = 0;
        hold = 1; sdf = 0; frc_r = 0; frc_p = 0; lng = 0;
        step(); step();
        rst = 1'b0;
    endtask

    // Lock event, then silence; expiry expected on edge n after the event.
    task automatic silent_window(string req, int n, logic lnk);
        for (int j = 1; j <= n; j++) begin
            step();
            chk(req, {lnk, (j < n), (j == n)});
        end
    endtask

    initial begin
        // R1: reset state, even with inputs active
        rst = 1'b1; sig = 1; dlk = 1; stb = 1; frc_r = 0;
        step(); chk("R1", 3'b000);
        step(); chk("R1", 3'b000);
        do_reset();
        step(); chk("R1", 3'b000);

        // R2 R3 R4 R5 R9: sweep hold / force-signal / signal level
        for (int h = 0; h < 2; h++) begin
            for (int f = 0; f < 2; f++) begin
                for (int s = 0; s < 2; s++) begin
                    logic up;
                    do_reset();
                    hold = h[0]; sdf = f[0]; sig = s[0];
                    up = s[0] | f[0];
                    dlk = 1; step();
                    chk("R2 R9 link on lock edge", {up, 1'b1, 1'b0});
                    dlk = 0; step();
                    chk("R11 unlock clears lock", {up, 1'b0, 1'b0});
                    step();
                    chk(h[0] ? "R3 hold keeps link" : "R4 drop after unlock",
                        {up & h[0], 1'b0, 1'b0});
                end
            end
        end

        // R5: signal loss drops link in hold mode at the sampling edge
        do_reset();
        sig = 1; dlk = 1; step(); chk("R5 setup", 3'b110);
        sig = 0; step(); chk("R5 signal loss", 3'b010);

        // R10: signal returns while lock still held: stays down
        sig = 1; step(); chk("R10 no fresh lock", 3'b010);
        step(); chk("R10 no fresh lock", 3'b010);
        dlk = 0; step(); chk("R10 lock withdrawn", 3'b000);
        dlk = 1; step(); chk("R10 fresh lock edge", 3'b110);

        // R2: lock edge with invalid signal leaves link down
        do_reset();
        dlk = 1; step(); chk("R2 no signal", 3'b010);
        sig = 1; step(); chk("R2 no signal", 3'b010);

        // R8: force sources, then release
        for (int k = 1; k < 4; k++) begin
            do_reset();
            frc_r = k[0]; frc_p = k[1];
            step(); chk("R8 forced", 3'b100);
            step(); chk("R8 forced", 3'b100);
            frc_r = 0; frc_p = 0;
            step(); chk("R8 released", 3'b000);
        end
        // R8: release with signal valid and lock held keeps link in hold mode
        do_reset();
        frc_p = 1; sig = 1; dlk = 1; step(); chk("R8 forced lock", 3'b110);
        frc_p = 0; step(); chk("R8 release normal", 3'b110);

        // R6: short window, every cycle checked
        do_reset();
        sig = 1; dlk = 1; step(); chk("R6 event", 3'b110);
        silent_window("R6 short window", NS, 1'b1);
        step(); chk("R6 single pulse", 3'b100);

        // R6: strobe gap of exactly N keeps lock
        do_reset();
        sig = 1; dlk = 1; step();
        for (int r = 0; r < 3; r++) begin
            repeat (NS - 1) step();
            stb = 1; step(); stb = 0;
            chk("R6 gap N holds", 3'b110);
        end
        // R6: strobe reload then silence gives expiry N after the strobe
        silent_window("R6 after strobe", NS, 1'b1);

        // R7: long window
        do_reset();
        lng = 1; sig = 1; dlk = 1; step(); chk("R7 event long", 3'b110);
        silent_window("R7 long window", NL, 1'b1);

        // R7: select change mid-window has no effect until reload
        do_reset();
        sig = 1; dlk = 1; step();
        lng = 1;
        silent_window("R7 deferred select", NS, 1'b1);
        dlk = 0; step(); lng = 0;
        dlk = 1; step();
        repeat (10) step();
        lng = 1; stb = 1; step(); stb = 0;
        chk("R7 reload picks long", 3'b110);
        silent_window("R7 long after reload", NL, 1'b1);

        // R4: timeout in drop mode takes link down one edge later
        do_reset();
        hold = 0; sig = 1; dlk = 1; step();
        repeat (NS - 1) step();
        chk("R4 pre-expiry", 3'b110);
        step(); chk("R4 expiry", 3'b101);
        step(); chk("R4 link drop", 3'b000);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nbad++;
            $display("FAIL watchdog: actual running, expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
            $finish;
        end
    end
endmodule